// File: doc/BRIEF.md
# Board Control Register Block with Interrupt Aggregation

This block is the register file of a small board-support controller. A host reaches it over a simple 32-bit bus with a select, a write flag, a byte address and write data; read data comes back in the same cycle. It holds eight plain 32-bit storage words for LED patterns, LED control, switch state and miscellaneous board signals. It also holds an interrupt enable word, an interrupt pending word and two card-slot words.

Sixteen level-sensitive interrupt lines come in from the board. While a line is high and its enable bit is set, its pending bit is set. That pending bit stays set after the line drops, until software overwrites the pending word. One registered output tells the host processor that at least one enabled bit is pending. The two slot words keep their upper bits fixed. Bit 5 of each slot word follows the inverse of one interrupt line, so it reads as an active-low card-present flag. The host may write only the low five bits of a slot word.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset, every storage word, the enable word and the pending word read 0. Both slot words read 0x0000_0420, which is bit 10 (ready) plus bit 5 (no card). `irqOut` is 0.
- R2: Each plain word stores and returns all 32 written bits. The word offsets are: LED word A 0x10, LED word B 0x14, LED control 0x40, switch 0x60, misc out 0x80, 0x84 and 0x88, misc in 0x90.
- R3: A read at an offset that is not in the map, or that is not word-aligned, returns 0. A write there changes no register.
- R4: The enable word is at 0xC0. A write stores the written value ANDed with 0x000F_EEFF.
- R5: The pending word is at 0xD0. A write replaces the stored value with the written value ANDed with 0x000F_EEFF, so one write can both set and clear bits.
- R6: Pending bit i (i < 16) is set at a clock edge when input line i is high and enable bit i is 1. It is not set while enable bit i is 0. Dropping the line does not clear it.
- R7: `irqOut` is high exactly when (pending AND enable) is nonzero. It follows a line change or a register write by one clock edge.
- R8: If a software write to the pending word and an enabled line assertion happen in the same cycle, the bit for that line ends up set.
- R9: The slot words are at 0xE0 (slot 0) and 0xE4 (slot 1). A write changes only bits [4:0]. Bit 10 stays 1, and bits [31:11] and [9:6] stay 0.
- R10: Slot bit 5 is 0 one edge after line 9 (slot 0) or line 13 (slot 1) is seen high, and returns to 1 one edge after that line is seen low.
- R11: Only address bits [7:0] are decoded. The higher bits of the 20-bit address are ignored, so the map repeats across the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 20 | Byte address inside the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| irqIn | input | 16 | Level-sensitive board interrupt lines |
| irqOut | output | 1 | Combined interrupt to the host, registered |

## Verification
The aggregation is driven with these line patterns:
- A mix of enabled and disabled lines raised together. This separates enable-gated latching from raw input capture.
- A line that rises and then falls. This shows that the pending bit is sticky and that the pin does not drive it directly.
- A line that rises in the same cycle as a software write that clears the pending word. This shows which of the two wins.
- The card-detect lines raised while their enable bits are off. This shows that slot bit 5 mirrors the pin even though no pending bit is latched.

The edge on which `irqOut` changes is checked against the cycle before it, which catches both a combinational path and an extra register. A vector table writes every word with patterns that the allow mask and the slot write mask would alter, and reads each word back.

// File: rtl/bcr_pkg.sv
`timescale 1ns/1ps
package bcr_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 8;

  // bits software and lines may hold in enable / pending words
  localparam logic [DATA_W-1:0] IRQ_ALLOW = 32'h000F_EEFF;

  localparam int SLOT_WR_W    = 5;
  localparam int SLOT_CD_BIT  = 5;
  localparam int SLOT_RDY_BIT = 10;
  localparam logic [DATA_W-1:0] SLOT_RESET =
    (DATA_W'(1) << SLOT_RDY_BIT) | (DATA_W'(1) << SLOT_CD_BIT);

  typedef enum logic [3:0] {
    IDX_LED_A   = 4'd0,
    IDX_LED_B   = 4'd1,
    IDX_LED_CTL = 4'd2,
    IDX_SWITCH  = 4'd3,
    IDX_MISC0   = 4'd4,
    IDX_MISC1   = 4'd5,
    IDX_MISC2   = 4'd6,
    IDX_MISC_IN = 4'd7,
    IDX_ENABLE  = 4'd8,
    IDX_PENDING = 4'd9,
    IDX_SLOT0   = 4'd10,
    IDX_SLOT1   = 4'd11
  } reg_idx_e;

  localparam int PLAIN_N = 8;
  localparam int SLOT_N  = 2;
  localparam int REG_N   = PLAIN_N + 2 + SLOT_N;

  localparam logic [OFF_W-1:0] OFF_LED_A   = 8'h10;
  localparam logic [OFF_W-1:0] OFF_LED_B   = 8'h14;
  localparam logic [OFF_W-1:0] OFF_LED_CTL = 8'h40;
  localparam logic [OFF_W-1:0] OFF_SWITCH  = 8'h60;
  localparam logic [OFF_W-1:0] OFF_MISC0   = 8'h80;
  localparam logic [OFF_W-1:0] OFF_MISC1   = 8'h84;
  localparam logic [OFF_W-1:0] OFF_MISC2   = 8'h88;
  localparam logic [OFF_W-1:0] OFF_MISC_IN = 8'h90;
  localparam logic [OFF_W-1:0] OFF_ENABLE  = 8'hC0;
  localparam logic [OFF_W-1:0] OFF_PENDING = 8'hD0;
  localparam logic [OFF_W-1:0] OFF_SLOT0   = 8'hE0;
  localparam logic [OFF_W-1:0] OFF_SLOT1   = 8'hE4;

  // control -> datapath strobes
  typedef struct packed {
    logic [REG_N-1:0] wrHot;
    logic             rdHit;
    reg_idx_e         rdIdx;
  } strobe_t;
endpackage

// File: rtl/bcr_decode.sv
`timescale 1ns/1ps
module bcr_decode
  import bcr_pkg::*;
(
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [OFF_W-1:0] busOff,
  output strobe_t          strobe
);
  logic     hit;
  reg_idx_e idx;

  // full 8-bit compare: misaligned offsets never match
  always_comb begin
    hit = 1'b1;
    idx = IDX_LED_A;
    unique case (busOff)
      OFF_LED_A:   idx = IDX_LED_A;
      OFF_LED_B:   idx = IDX_LED_B;
      OFF_LED_CTL: idx = IDX_LED_CTL;
      OFF_SWITCH:  idx = IDX_SWITCH;
      OFF_MISC0:   idx = IDX_MISC0;
      OFF_MISC1:   idx = IDX_MISC1;
      OFF_MISC2:   idx = IDX_MISC2;
      OFF_MISC_IN: idx = IDX_MISC_IN;
      OFF_ENABLE:  idx = IDX_ENABLE;
      OFF_PENDING: idx = IDX_PENDING;
      OFF_SLOT0:   idx = IDX_SLOT0;
      OFF_SLOT1:   idx = IDX_SLOT1;
      default:     hit = 1'b0;
    endcase
  end

  always_comb begin
    strobe.wrHot = '0;
    if (busSel && busWrite && hit)
      strobe.wrHot = REG_N'(1) << idx;
    strobe.rdHit = busSel && !busWrite && hit;
    strobe.rdIdx = idx;
  end
endmodule

// File: rtl/bcr_regs.sv
`timescale 1ns/1ps
module bcr_regs
  import bcr_pkg::*;
#(
  parameter int IRQ_N    = 16,
  parameter int CD_LINE0 = 9,
  parameter int CD_LINE1 = 13
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       strobe,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [IRQ_N-1:0]              irqIn,
  output logic [DATA_W-1:0]             rdData,
  output logic                          irqOut,
  output logic [DATA_W-1:0]             enableQ,
  output logic [DATA_W-1:0]             pendQ,
  output logic [SLOT_N-1:0][DATA_W-1:0] slotQ
);
  logic [DATA_W-1:0] regView [REG_N];
  logic [DATA_W-1:0] irqWide;
  logic [DATA_W-1:0] enableNext, pendBase, pendNext;
  logic              irqOutQ;

  assign irqWide = DATA_W'(irqIn);

  // plain storage words
  for (genvar p = 0; p < PLAIN_N; p++) begin : gPlain
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (rst)                 word <= '0;
      else if (strobe.wrHot[p]) word <= wrData;
    end
    assign regView[p] = word;
  end

  // enable / pending: the line-driven set is ORed in after the software value
  always_comb begin
    enableNext = strobe.wrHot[IDX_ENABLE] ? (wrData & IRQ_ALLOW) : enableQ;
    pendBase   = strobe.wrHot[IDX_PENDING] ? (wrData & IRQ_ALLOW) : pendQ;
    pendNext   = pendBase | (irqWide & enableQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enableQ <= '0;
      pendQ   <= '0;
      irqOutQ <= 1'b0;
    end else begin
      enableQ <= enableNext;
      pendQ   <= pendNext;
      irqOutQ <= |(pendNext & enableNext);
    end
  end

  assign irqOut = irqOutQ;
  assign regView[IDX_ENABLE]  = enableQ;
  assign regView[IDX_PENDING] = pendQ;

  // card-slot words
  for (genvar s = 0; s < SLOT_N; s++) begin : gSlot
    localparam int LINE   = (s == 0) ? CD_LINE0 : CD_LINE1;
    localparam int WR_IDX = int'(IDX_SLOT0) + s;
    logic [DATA_W-1:0] slotWord;
    always_ff @(posedge clk) begin
      if (rst) begin
        slotWord <= SLOT_RESET;
      end else begin
        if (strobe.wrHot[WR_IDX])
          slotWord[SLOT_WR_W-1:0] <= wrData[SLOT_WR_W-1:0];
        slotWord[SLOT_CD_BIT] <= ~irqIn[LINE];
      end
    end
    assign slotQ[s]        = slotWord;
    assign regView[WR_IDX] = slotWord;
  end

  assign rdData = strobe.rdHit ? regView[strobe.rdIdx] : '0;
endmodule

// File: rtl/board_ctrl_regs.sv
`timescale 1ns/1ps
module board_ctrl_regs
  import bcr_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int IRQ_N    = 16,
  parameter int CD_LINE0 = 9,
  parameter int CD_LINE1 = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [IRQ_N-1:0]  irqIn,
  output logic              irqOut
);
  strobe_t                       strobe;
  logic [DATA_W-1:0]             enableQ, pendQ, slot0Q, slot1Q;
  logic [SLOT_N-1:0][DATA_W-1:0] slotQ;
  logic                          unusedAddrHigh;

  // upper address bits only alias the map
  assign unusedAddrHigh = ^busAddr[ADDR_W-1:OFF_W];

  bcr_decode uDecode (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busOff   (busAddr[OFF_W-1:0]),
    .strobe   (strobe)
  );

  bcr_regs #(
    .IRQ_N    (IRQ_N),
    .CD_LINE0 (CD_LINE0),
    .CD_LINE1 (CD_LINE1)
  ) uRegs (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .wrData  (busWdata),
    .irqIn   (irqIn),
    .rdData  (busRdata),
    .irqOut  (irqOut),
    .enableQ (enableQ),
    .pendQ   (pendQ),
    .slotQ   (slotQ)
  );

  assign slot0Q = slotQ[0];
  assign slot1Q = slotQ[1];
endmodule

// File: rtl/board_ctrl_regs_checker.sv
`timescale 1ns/1ps
module board_ctrl_regs_checker
  import bcr_pkg::*;
#(
  parameter int IRQ_N    = 16,
  parameter int CD_LINE0 = 9,
  parameter int CD_LINE1 = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              busSel,
  input logic              busWrite,
  input logic [OFF_W-1:0]  busOff,
  input logic [31:0]       busRdata,
  input logic [IRQ_N-1:0]  irqIn,
  input logic              irqOut,
  input logic [31:0]       enableQ,
  input logic [31:0]       pendQ,
  input logic [31:0]       slot0Q,
  input logic [31:0]       slot1Q
);
  logic [31:0] irqWide;
  logic        pendWrite;
  assign irqWide   = 32'(irqIn);
  assign pendWrite = busSel && busWrite && (busOff == OFF_PENDING);

  assert_irq_combined_R7: assert property (@(posedge clk) disable iff (rst)
    irqOut == |(pendQ & enableQ));

  assert_allowed_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (enableQ & ~IRQ_ALLOW) == 32'd0);

  assert_allowed_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (pendQ & ~IRQ_ALLOW) == 32'd0);

  // covers the R8 conflict case too
  assert_pend_set_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pendQ & $past(irqWide & enableQ)) == $past(irqWide & enableQ)));

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !pendWrite |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  assert_slot0_cd_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (slot0Q[SLOT_CD_BIT] == !$past(irqIn[CD_LINE0])));

  assert_slot1_cd_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (slot1Q[SLOT_CD_BIT] == !$past(irqIn[CD_LINE1])));

  assert_slot_upper_R9: assert property (@(posedge clk) disable iff (rst)
    (slot0Q[31:6] == 26'h10) && (slot1Q[31:6] == 26'h10));

  assert_misaligned_read_R3: assert property (@(posedge clk) disable iff (rst)
    (busSel && !busWrite && (busOff[1:0] != 2'b00)) |-> (busRdata == 32'd0));
endmodule

bind board_ctrl_regs board_ctrl_regs_checker #(
  .IRQ_N    (IRQ_N),
  .CD_LINE0 (CD_LINE0),
  .CD_LINE1 (CD_LINE1)
) uChecker (
  .clk      (clk),
  .rst      (rst),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busOff   (busAddr[7:0]),
  .busRdata (busRdata),
  .irqIn    (irqIn),
  .irqOut   (irqOut),
  .enableQ  (enableQ),
  .pendQ    (pendQ),
  .slot0Q   (slot0Q),
  .slot1Q   (slot1Q)
);

// File: tb/board_ctrl_regs_test.sv
`timescale 1ns/1ps
module board_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [19:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] irqIn = '0;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  board_ctrl_regs uut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  // {address, write data, expected readback}
  localparam logic [95:0] VEC [12] = '{
    {32'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R2
    {32'h14, 32'h0123_4567, 32'h0123_4567},   // R2
    {32'h40, 32'hA5A5_A5A5, 32'hA5A5_A5A5},   // R2
    {32'h60, 32'hFFFF_FFFF, 32'hFFFF_FFFF},   // R2
    {32'h80, 32'h8000_0001, 32'h8000_0001},   // R2
    {32'h84, 32'h1357_9BDF, 32'h1357_9BDF},   // R2
    {32'h88, 32'h2468_ACE0, 32'h2468_ACE0},   // R2
    {32'h90, 32'h0F0F_0F0F, 32'h0F0F_0F0F},   // R2
    {32'hC0, 32'hFFFF_FFFF, 32'h000F_EEFF},   // R4
    {32'hD0, 32'hFFFF_FFFF, 32'h000F_EEFF},   // R5
    {32'hE0, 32'hFFFF_FFFF, 32'h0000_043F},   // R9
    {32'hE4, 32'hFFFF_FFE0, 32'h0000_0420}    // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic doWriteIrq(input logic [19:0] a, input logic [31:0] d, input logic [15:0] irq);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; irqIn = irq;
    @(posedge clk);
    #1 busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doWrite(input logic [19:0] a, input logic [31:0] d);
    doWriteIrq(a, d, irqIn);
  endtask

  task automatic doRead(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk);
    #1 busSel = 1'b0;
  endtask

  task automatic expectRead(input string req, input logic [19:0] a, input logic [31:0] exp);
    logic [31:0] d;
    doRead(a, d);
    check(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    check("R1 irqOut", {31'd0, irqOut}, 32'd0);
    for (int i = 0; i < 12; i++) begin
      logic [19:0] a = VEC[i][83:64];
      expectRead("R1 reset word", a, (a[7:0] >= 8'hE0) ? 32'h0000_0420 : 32'd0);
    end

    // vector table: write then read back
    for (int i = 0; i < 12; i++) begin
      doWrite(VEC[i][83:64], VEC[i][63:32]);
      expectRead("R2/R4/R5/R9 table", VEC[i][83:64], VEC[i][31:0]);
    end
    check("R7 irqOut after enabled pending", {31'd0, irqOut}, 32'd1);

    // R3 undecoded and misaligned
    expectRead("R3 undecoded read", 20'h000A0, 32'd0);
    expectRead("R3 misaligned read", 20'h00012, 32'd0);
    doWrite(20'h00011, 32'h0000_0000);
    expectRead("R3 misaligned write ignored", 20'h00010, 32'hDEAD_BEEF);
    doWrite(20'h000F0, 32'h0000_0000);
    expectRead("R3 undecoded write ignored", 20'h000C0, 32'h000F_EEFF);

    // R11 upper address bits ignored
    expectRead("R11 alias read", 20'hABC10, 32'hDEAD_BEEF);
    doWrite(20'h55514, 32'hCAFE_F00D);
    expectRead("R11 alias write", 20'h00014, 32'hCAFE_F00D);

    // R5 overwrite clears, R7 follows
    doWrite(20'h000D0, 32'h0000_0003);
    expectRead("R5 overwrite", 20'h000D0, 32'h0000_0003);
    check("R7 irqOut still high", {31'd0, irqOut}, 32'd1);
    doWrite(20'h000D0, 32'h0000_0000);
    check("R7 irqOut cleared", {31'd0, irqOut}, 32'd0);

    // R6 enable gating, R7 timing, R10 mirror
    doWrite(20'h000C0, 32'h0000_0200);
    @(negedge clk);
    irqIn = 16'h2208;
    #1 check("R7 no combinational path", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    check("R7 one edge later", {31'd0, irqOut}, 32'd1);
    expectRead("R6 only enabled line pends", 20'h000D0, 32'h0000_0200);
    expectRead("R10 slot0 card present", 20'h000E0, 32'h0000_041F);
    expectRead("R10 slot1 card present", 20'h000E4, 32'h0000_0400);
    @(negedge clk);
    irqIn = 16'h0000;
    @(negedge clk);
    expectRead("R6 sticky after line drop", 20'h000D0, 32'h0000_0200);
    expectRead("R10 slot0 card removed", 20'h000E0, 32'h0000_043F);
    check("R7 irqOut held", {31'd0, irqOut}, 32'd1);

    // R8 line set beats same-cycle clear
    doWrite(20'h000D0, 32'h0000_0000);
    expectRead("R8 cleared first", 20'h000D0, 32'd0);
    doWriteIrq(20'h000D0, 32'h0000_0000, 16'h0200);
    @(negedge clk);
    irqIn = 16'h0000;
    expectRead("R8 line wins", 20'h000D0, 32'h0000_0200);
    doWrite(20'h000D0, 32'h0000_0000);
    check("R7 irqOut low at end", {31'd0, irqOut}, 32'd0);

    // R9 slot upper bits kept across write
    doWrite(20'h000E4, 32'hFFFF_FC0A);
    expectRead("R9 slot1 low bits only", 20'h000E4, 32'h0000_042A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule